// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two parallel ports, side A and side B. Each direction has its own capture register, its own capture strobe, a select that picks live or stored data, and an output enable. The A-to-B enable is active high and the B-to-A enable is active low. With these controls the block can isolate both sides, pass live data either way, replay a stored word either way, or fill one or both registers while the ports are idle.

Each tri-state side is modelled as three separate vectors: an input, an output and an output enable. A pad ring or a testbench can then act as the external bus driver. A parameter sets the data path to pass data unchanged or to complement it, and the same setting applies to both directions.

Both directions can be enabled and told to pass live data at once. That would form a combinational loop, so in that case the block sends the stored words both ways and raises a flag. The asynchronous active-low reset clears both registers, and its release is synchronised to the clock.

Top module: `bxr_transceiver`

## Requirements
- R1: The A register loads the value present on side A in every cycle where `cap_ab` is 1, whatever the enables are set to. It keeps its value in every other cycle. The value present on a side is the block's own output when the block drives that side, and the external input otherwise.
- R2: The B register loads the value present on side B in every cycle where `cap_ba` is 1, whatever the enables are set to. It keeps its value in every other cycle.
- R3: When `oe_ab` is 1, every bit of `b_oe` is 1. When `oe_ab` is 0, `b_oe` and `b_out` are all zeros.
- R4: When `oe_ba_n` is 0, every bit of `a_oe` is 1. When `oe_ba_n` is 1, `a_oe` and `a_out` are all zeros.
- R5: While side B is driven, `sel_ab` = 0 puts the side A value on `b_out` and `sel_ab` = 1 puts the A register contents there, after the polarity of R10.
- R6: While side A is driven, `sel_ba` = 0 puts the side B value on `a_out` and `sel_ba` = 1 puts the B register contents there, after the polarity of R10.
- R7: With `oe_ab` = 0 and `oe_ba_n` = 1, neither side is driven. Either register or both can still be loaded from its external input.
- R8: When one side is driven with live data from the other side and the opposite capture strobe is 1, the driven word is captured. One strobe cycle can therefore leave the same word in both registers.
- R9: When both sides are driven and both selects are 0, `b_out` carries the A register contents, `a_out` carries the B register contents, and `loop_err` is 1. In every other case `loop_err` is 0.
- R10: With `POL` = POL_INVERT, both directions output the bitwise complement of the selected word. With POL_PASS, both directions output the word unchanged.
- R11: `rst_n` = 0 clears both registers at once, without waiting for a clock. After `rst_n` returns to 1, the block resumes operation within two clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both registers and the reset synchroniser |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_ab | input | 1 | Drive side B (active high) |
| oe_ba_n | input | 1 | Drive side A (active low) |
| sel_ab | input | 1 | Towards B: 0 live side A, 1 stored A word |
| sel_ba | input | 1 | Towards A: 0 live side B, 1 stored B word |
| cap_ab | input | 1 | Load the A register this cycle |
| cap_ba | input | 1 | Load the B register this cycle |
| a_in | input | W | External value on side A |
| a_out | output | W | Value the block drives on side A |
| a_oe | output | W | Per-bit drive enable for side A |
| b_in | input | W | External value on side B |
| b_out | output | W | Value the block drives on side B |
| b_oe | output | W | Per-bit drive enable for side B |
| loop_err | output | 1 | Both sides driven with live data; stored words substituted |

## Verification
The assertions check the following on every cycle: the idle state of each side when its enable is off, the stored-word output whenever a select is 1, the stored-word substitution while `loop_err` is high, and the load-or-hold behaviour of both registers. Only the bench's scenarios can show the remaining behaviour. This covers the live pass-through values and a word passing through both registers in one strobe cycle. It also covers both polarities side by side, the asynchronous clear, and every one of the sixteen enable and select combinations under all four strobe pairs.

// File: rtl/bxr_pkg.sv
package bxr_pkg;
  // Data path polarity, shared by both directions.
  typedef enum logic {
    POL_PASS   = 1'b0,
    POL_INVERT = 1'b1
  } pol_e;
endpackage

// File: rtl/bxr_rst_sync.sv
// Reset assertion is asynchronous; release is delayed through STAGES flops.
module bxr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES > 1) begin : g_chain
      always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};
    end else begin : g_single
      always_comb sh_d = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sn = sh_q[LAST];
endmodule

// File: rtl/bxr_store_reg.sv
// Capture register with an explicit load enable.
module bxr_store_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_q;
  logic [W-1:0] q_d;

  always_comb q_d = cap ? d : q_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q = q_q;

  // R1 for the A instance, R2 for the B instance
  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (q == $past(d)));
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(q));
endmodule

// File: rtl/bxr_lane.sv
// One direction: live/stored pick followed by the polarity stage.
module bxr_lane
  import bxr_pkg::*;
#(
  parameter int   W   = 8,
  parameter pol_e POL = POL_PASS
) (
  input  logic         live,
  input  logic [W-1:0] stored,
  input  logic [W-1:0] live_src,
  output logic [W-1:0] val
);
  logic [W-1:0] picked;

  always_comb picked = live ? live_src : stored;

  generate
    if (POL == POL_INVERT) begin : g_inv
      assign val = ~picked;
    end else begin : g_pass
      assign val = picked;
    end
  endgenerate
endmodule

// File: rtl/bxr_transceiver.sv
module bxr_transceiver
  import bxr_pkg::*;
#(
  parameter int   W           = 8,
  parameter pol_e POL         = POL_PASS,
  parameter int   SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         oe_ab,
  input  logic         oe_ba_n,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  output logic         loop_err
);
  logic         rst_sn;
  logic         drive_a, drive_b, loop_hit, live_ab, live_ba;
  logic [W-1:0] reg_a_q, reg_b_q;
  logic [W-1:0] echo_a, echo_b;
  logic [W-1:0] b_src_for_a, a_val, a_port, b_val, b_port;

  bxr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  // Enable decode and loop breaking
  always_comb begin
    drive_a  = ~oe_ba_n;
    drive_b  = oe_ab;
    loop_hit = drive_a & drive_b & ~sel_ab & ~sel_ba;
    live_ab  = ~sel_ab & ~loop_hit;
    live_ba  = ~sel_ba & ~loop_hit;
  end

  // Stored words after polarity, always available
  bxr_lane #(.W(W), .POL(POL)) u_echo_a (
    .live(1'b0), .stored(reg_a_q), .live_src('0), .val(echo_a)
  );
  bxr_lane #(.W(W), .POL(POL)) u_echo_b (
    .live(1'b0), .stored(reg_b_q), .live_src('0), .val(echo_b)
  );

  // If B is driven while A takes live B data, B must carry the stored A word
  always_comb b_src_for_a = drive_b ? echo_a : b_in;

  bxr_lane #(.W(W), .POL(POL)) u_lane_ba (
    .live(live_ba), .stored(reg_b_q), .live_src(b_src_for_a), .val(a_val)
  );

  always_comb a_port = drive_a ? a_val : a_in;

  bxr_lane #(.W(W), .POL(POL)) u_lane_ab (
    .live(live_ab), .stored(reg_a_q), .live_src(a_port), .val(b_val)
  );

  always_comb b_port = drive_b ? b_val : b_in;

  bxr_store_reg #(.W(W)) u_reg_a (
    .clk(clk), .rst_n(rst_sn), .cap(cap_ab), .d(a_port), .q(reg_a_q)
  );
  bxr_store_reg #(.W(W)) u_reg_b (
    .clk(clk), .rst_n(rst_sn), .cap(cap_ba), .d(b_port), .q(reg_b_q)
  );

  assign a_out    = drive_a ? a_val : '0;
  assign b_out    = drive_b ? b_val : '0;
  assign a_oe     = {W{drive_a}};
  assign b_oe     = {W{drive_b}};
  assign loop_err = loop_hit;

  p_b_idle_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    !oe_ab |-> (b_oe == '0 && b_out == '0));
  p_a_idle_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    oe_ba_n |-> (a_oe == '0 && a_out == '0));
  p_stored_ab_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (oe_ab && sel_ab) |-> (b_out == echo_a));
  p_stored_ba_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (!oe_ba_n && sel_ba) |-> (a_out == echo_b));
  p_loop_safe_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    loop_err |-> (b_out == echo_a && a_out == echo_b && a_oe != '0 && b_oe != '0));
endmodule

// File: tb/bxr_transceiver_bench.sv
module bxr_transceiver_bench;
  import bxr_pkg::*;
  localparam int W = 8;
  localparam int WATCHDOG_CYCLES = 100000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, oe_ab, oe_ba_n, sel_ab, sel_ba, cap_ab, cap_ba;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_out_p, a_oe_p, b_out_p, b_oe_p;
  logic [W-1:0] a_out_i, a_oe_i, b_out_i, b_oe_i;
  logic         loop_p, loop_i;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] ea [2];
  logic [W-1:0] eb [2];
  logic [W-1:0] pa [2];
  logic [W-1:0] pb [2];

  bxr_transceiver #(.W(W), .POL(POL_PASS)) u_bxr_transceiver (
    .clk(clk), .rst_n(rst_n), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .a_in(a_in), .a_out(a_out_p), .a_oe(a_oe_p),
    .b_in(b_in), .b_out(b_out_p), .b_oe(b_oe_p), .loop_err(loop_p)
  );

  bxr_transceiver #(.W(W), .POL(POL_INVERT)) u_bxr_transceiver_inv (
    .clk(clk), .rst_n(rst_n), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .a_in(a_in), .a_out(a_out_i), .a_oe(a_oe_i),
    .b_in(b_in), .b_out(b_out_i), .b_oe(b_oe_i), .loop_err(loop_i)
  );

  function automatic logic [W-1:0] pf(input bit inv, input logic [W-1:0] x);
    return inv ? ~x : x;
  endfunction

  // Side values settle by repeated evaluation of the bus rules (R5, R6, R9, R10)
  task automatic model(input bit inv, input logic [W-1:0] ra, input logic [W-1:0] rb,
                       output logic [W-1:0] ao, output logic [W-1:0] bo,
                       output logic [W-1:0] xa, output logic [W-1:0] xb, output bit lp);
    bit da, db;
    logic [W-1:0] av, bv;
    da = !oe_ba_n;
    db = oe_ab;
    lp = da && db && !sel_ab && !sel_ba;
    xa = a_in;
    xb = b_in;
    av = '0;
    bv = '0;
    for (int it = 0; it < 3; it++) begin
      av = (sel_ba || lp) ? pf(inv, rb) : pf(inv, xb);
      bv = (sel_ab || lp) ? pf(inv, ra) : pf(inv, xa);
      xa = da ? av : a_in;
      xb = db ? bv : b_in;
    end
    ao = da ? av : '0;
    bo = db ? bv : '0;
  endtask

  task automatic check_step(input string tag);
    for (int k = 0; k < 2; k++) begin
      logic [W-1:0] ao, bo, xa, xb, act_ao, act_bo, act_aoe, act_boe, exp_aoe, exp_boe;
      bit lp;
      logic act_lp;
      model(k == 1, ea[k], eb[k], ao, bo, xa, xb, lp);
      pa[k] = xa;
      pb[k] = xb;
      exp_aoe = {W{!oe_ba_n}};
      exp_boe = {W{oe_ab}};
      act_ao  = k ? a_out_i : a_out_p;
      act_bo  = k ? b_out_i : b_out_p;
      act_aoe = k ? a_oe_i  : a_oe_p;
      act_boe = k ? b_oe_i  : b_oe_p;
      act_lp  = k ? loop_i  : loop_p;
      checks++;
      if (act_ao !== ao || act_bo !== bo || act_aoe !== exp_aoe ||
          act_boe !== exp_boe || act_lp !== lp) begin
        fails++;
        $display("FAIL %s%s: a_out=%h b_out=%h a_oe=%h b_oe=%h loop=%b expected a_out=%h b_out=%h a_oe=%h b_oe=%h loop=%b",
                 tag, k ? " R10" : "", act_ao, act_bo, act_aoe, act_boe, act_lp,
                 ao, bo, exp_aoe, exp_boe, lp);
      end
    end
  endtask

  task automatic step(input logic oab, input logic obn, input logic sab, input logic sba,
                      input logic cab, input logic cba,
                      input logic [W-1:0] ai, input logic [W-1:0] bi, input string tag);
    @(negedge clk);
    oe_ab = oab; oe_ba_n = obn; sel_ab = sab; sel_ba = sba;
    cap_ab = cab; cap_ba = cba; a_in = ai; b_in = bi;
    #2 check_step(tag);
    @(posedge clk);
    #1;
    for (int k = 0; k < 2; k++) begin
      if (cab) ea[k] = pa[k];
      if (cba) eb[k] = pb[k];
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, actual=%0d cycles expected=fewer", WATCHDOG_CYCLES);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; oe_ab = 1'b0; oe_ba_n = 1'b1; sel_ab = 1'b0; sel_ba = 1'b0;
    cap_ab = 1'b0; cap_ba = 1'b0; a_in = '0; b_in = '0;
    for (int k = 0; k < 2; k++) begin ea[k] = '0; eb[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R11: cleared registers replayed both ways
    step(1, 0, 1, 1, 0, 0, 8'h3C, 8'hC3, "R11");

    // R7 + R1 + R2: isolated load of both registers, then replay
    step(0, 1, 0, 0, 1, 1, 8'h5A, 8'hA5, "R7");
    step(1, 0, 1, 1, 0, 0, 8'h00, 8'hFF, "R1 R2");
    // R1: hold with strobes low and new inputs
    step(0, 1, 0, 0, 0, 0, 8'h11, 8'h22, "R1");
    step(1, 0, 1, 1, 0, 0, 8'h00, 8'h00, "R1 R2");

    // R8: live B to A while both strobes fire
    step(0, 0, 0, 0, 1, 1, 8'hEE, 8'hC3, "R8");
    step(1, 0, 1, 1, 0, 0, 8'h00, 8'h00, "R8");
    // R8: live A to B while both strobes fire
    step(1, 1, 0, 0, 1, 1, 8'h96, 8'h0F, "R8");
    step(1, 0, 1, 1, 0, 0, 8'h00, 8'h00, "R8");

    // R3 R4 R5 R6: live each way, no capture
    step(1, 1, 0, 0, 0, 0, 8'h81, 8'h7E, "R5");
    step(0, 0, 0, 0, 0, 0, 8'h81, 8'h7E, "R6");
    step(0, 1, 1, 1, 0, 0, 8'h81, 8'h7E, "R3 R4");

    // R9: loop with capture
    step(1, 0, 0, 0, 1, 1, 8'hF0, 8'h0F, "R9");

    // Sweep every enable/select combination under every strobe pair
    for (int c = 0; c < 16; c++) begin
      for (int s = 0; s < 4; s++) begin
        for (int p = 0; p < 4; p++) begin
          logic [W-1:0] av, bv;
          string tag;
          av = W'(c * 37 + s * 11 + p * 73 + 5);
          bv = W'(c * 59 + s * 23 + p * 101 + 9);
          if (c[3] && !c[2] && !c[1] && !c[0])       tag = "R9";
          else if (!c[3] && c[2])                    tag = "R7";
          else if (c[3])                             tag = "R5";
          else                                       tag = "R6";
          step(c[3], c[2], c[1], c[0], s[1], s[0], av, bv, tag);
        end
      end
    end

    // R11: asynchronous clear mid-run, checked before any clock edge
    step(0, 1, 0, 0, 1, 1, 8'h6B, 8'hB6, "R11");
    @(negedge clk);
    oe_ab = 1'b1; oe_ba_n = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1;
    cap_ab = 1'b0; cap_ba = 1'b0;
    rst_n = 1'b0;
    for (int k = 0; k < 2; k++) begin ea[k] = '0; eb[k] = '0; end
    #2 check_step("R11");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    step(1, 0, 1, 1, 0, 0, 8'h00, 8'h00, "R11");
    step(0, 1, 0, 0, 1, 0, 8'h44, 8'h00, "R11");
    step(1, 0, 1, 1, 0, 0, 8'h00, 8'h00, "R11");

    finish_run();
  end
endmodule